// File: doc/BRIEF.md
# Single-Channel PWM Timer with Double-Buffered Period and Compare

This block is an up-counting PWM generator with one output. Software writes a period value and a compare value through a small synchronous register port. Those writes land in holding (preload) registers. The counter and the comparator never see them directly. Both values move into the working (active) registers together, and only on an update event. So a new period and a new duty cycle always take effect as a matched pair.

An update event happens in two cases. The first is when the counter wraps from the active period back to zero. The second is when software writes a one to the event-trigger register, which forces an update at once and restarts the counter. A hold-off control bit suppresses all update events. Software can therefore rewrite both preload values without a wrap landing between the two writes.

A two-bit mode field selects the output source:
- the normal PWM comparison,
- a constant high level,
- a constant low level.

While the output is forced, the counter and the update events keep running in the background.

Top module: `pwm_shadow_timer`

## Requirements
- R1: The counter counts up from 0 to the active period and then returns to 0, so one PWM cycle lasts period + 1 clocks. Reaching the period while counting is enabled is an update event.
- R2: In PWM mode the output is high exactly while the counter is below the active compare value. A compare of 0 never drives the output high. A compare of N (N ≤ period) gives an N-clock high pulse at the start of each cycle.
- R3: A compare value larger than the period holds the output high continuously. A compare value equal to the period gives one low clock per cycle.
- R4: Writing a word with bit 0 set to the event register (offset 1) is a forced update. The active pair loads and the counter restarts at 0 on the next clock, whatever the counter value was. A word with bit 0 clear written there has no effect.
- R5: While the hold-off bit (control bit 1) is set, no update event occurs, neither from a wrap nor from a forced write. The active registers keep their values, the update flag stays low, and a forced write does not restart the counter. Wrapping still happens.
- R6: Writes to the period register (offset 2) and the compare register (offset 3) change the output behaviour only after the next update event. On that event both values load together.
- R7: The update flag output is high for exactly the one clock that follows each unsuppressed update event. This is also the first clock in which the newly loaded values are active.
- R8: Control bits 3:2 select the output source:
  - 0 selects PWM,
  - 1 selects constant high,
  - 2 or 3 selects constant low.

  The mode takes effect in the clock after the control write. The counter and the update events continue in every mode.
- R9: With the run bit (control bit 0) clear, the counter holds its value, no wrap occurs, and the PWM output keeps its level.
- R10: A read strobe returns data on rdData in the following clock:
  - offset 0 returns the control bits 3:0,
  - offset 1 returns 0,
  - offsets 2 and 3 return the preload values.
- R11: After reset the following hold:
  - the control bits are 0;
  - the preload and active period are all ones;
  - the preload and active compare are 0;
  - the counter is 0;
  - the output and the update flag are low.
- R12: Loading a period of 0 and a compare of all ones, followed by a forced update, drives the output high from the next clock on, and raises an update event on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Register offset (0 control, 1 event, 2 period, 3 compare) |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid the clock after rdEn |
| pwmOut | output | 1 | PWM or forced output level |
| updateFlag | output | 1 | One-clock pulse after each update event |

## Verification
The checker covers, on every clock, the invariants that hold cycle by cycle:
- the counter never passes the active period;
- the active pair changes only together with the update flag;
- the hold-off bit blocks the flag;
- a forced write restarts the counter;
- counting continues in forced modes and stops when the run bit is clear;
- the output level follows from the compare being zero, the compare lying above the period, and forced high.

The bench scenarios show what only a sequence can show:
- the exact pulse widths and cycle lengths for several period and compare pairs;
- preload writes that stay invisible until an update;
- a suppressed forced write that leaves the pattern's phase untouched;
- the immediate switch to a constant high level through a zero period.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  // Register offsets on the 2-bit address port
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EVENT   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_COMPARE = 2'd3;

  // Bit positions inside the control register
  localparam int unsigned CTRL_RUN_BIT   = 0;
  localparam int unsigned CTRL_HOLD_BIT  = 1;
  localparam int unsigned CTRL_MODE_LSB  = 2;
  localparam int unsigned MODE_W         = 2;
  localparam int unsigned EVENT_GEN_BIT  = 0;

  typedef enum logic [MODE_W-1:0] {
    OUT_PWM     = 2'd0,
    OUT_HIGH    = 2'd1,
    OUT_LOW     = 2'd2,
    OUT_LOW_ALT = 2'd3
  } outMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     countEn;
    logic     loadShadow;
    logic     clearCount;
    outMode_e outMode;
  } dpCtrl_t;

endpackage

// File: rtl/pwm_reg_ctrl.sv
module pwm_reg_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned        DATA_W     = 16,
  parameter logic [DATA_W-1:0]  PERIOD_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              atPeriodEnd,
  output dpCtrl_t           dpCtrl,
  output logic [DATA_W-1:0] prePeriod,
  output logic [DATA_W-1:0] preCompare,
  output logic [DATA_W-1:0] rdData,
  output logic              updateFlag,
  output logic              updateDisable
);

  localparam int unsigned CTRL_BITS = CTRL_MODE_LSB + MODE_W;

  logic     runBit;
  logic     holdBit;
  outMode_e modeSel;

  logic wrCtrl, wrPeriod, wrCompare, genHit;
  logic wrapEvt, updEvt;
  logic [DATA_W-1:0] rdNext;
  logic [CTRL_BITS-1:0] ctrlView;

  // Write decode
  always_comb begin
    wrCtrl    = wrEn && (addr == ADDR_CTRL);
    wrPeriod  = wrEn && (addr == ADDR_PERIOD);
    wrCompare = wrEn && (addr == ADDR_COMPARE);
    genHit    = wrEn && (addr == ADDR_EVENT) && wrData[EVENT_GEN_BIT];
  end

  // Update-event generation
  always_comb begin
    wrapEvt = runBit && atPeriodEnd;
    updEvt  = (wrapEvt || genHit) && !holdBit;
  end

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      holdBit <= 1'b0;
      modeSel <= OUT_PWM;
    end else if (wrCtrl) begin
      runBit  <= wrData[CTRL_RUN_BIT];
      holdBit <= wrData[CTRL_HOLD_BIT];
      modeSel <= outMode_e'(wrData[CTRL_MODE_LSB +: MODE_W]);
    end
  end

  // Preload registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prePeriod  <= PERIOD_RST;
      preCompare <= '0;
    end else begin
      if (wrPeriod)  prePeriod  <= wrData;
      if (wrCompare) preCompare <= wrData;
    end
  end

  // Flag aligned with the first clock of the new active pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updateFlag <= 1'b0;
    else       updateFlag <= updEvt;
  end

  // Read path
  always_comb begin
    ctrlView = '0;
    ctrlView[CTRL_RUN_BIT]              = runBit;
    ctrlView[CTRL_HOLD_BIT]             = holdBit;
    ctrlView[CTRL_MODE_LSB +: MODE_W]   = modeSel;
    rdNext = '0;
    unique case (addr)
      ADDR_CTRL:    rdNext[CTRL_BITS-1:0] = ctrlView;
      ADDR_EVENT:   rdNext = '0;
      ADDR_PERIOD:  rdNext = prePeriod;
      ADDR_COMPARE: rdNext = preCompare;
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  // Strobes to datapath
  always_comb begin
    dpCtrl.countEn    = runBit;
    dpCtrl.loadShadow = updEvt;
    dpCtrl.clearCount = genHit && !holdBit;
    dpCtrl.outMode    = modeSel;
    updateDisable     = holdBit;
  end

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned        DATA_W     = 16,
  parameter logic [DATA_W-1:0]  PERIOD_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] prePeriod,
  input  logic [DATA_W-1:0] preCompare,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] actPeriod,
  output logic [DATA_W-1:0] actCompare,
  output logic              atPeriodEnd,
  output logic              pwmOut
);

  logic pwmActive;

  assign atPeriodEnd = (cnt == actPeriod);

  // Active (shadow) pair, loaded together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPeriod  <= PERIOD_RST;
      actCompare <= '0;
    end else if (dpCtrl.loadShadow) begin
      actPeriod  <= prePeriod;
      actCompare <= preCompare;
    end
  end

  // Up-counter with wrap at the active period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (dpCtrl.clearCount) begin
      cnt <= '0;
    end else if (dpCtrl.countEn) begin
      if (atPeriodEnd) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // Compare and output source select
  always_comb begin
    pwmActive = (cnt < actCompare);
    unique case (dpCtrl.outMode)
      OUT_PWM:     pwmOut = pwmActive;
      OUT_HIGH:    pwmOut = 1'b1;
      OUT_LOW:     pwmOut = 1'b0;
      OUT_LOW_ALT: pwmOut = 1'b0;
      default:     pwmOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned        DATA_W     = 16,
  parameter logic [DATA_W-1:0]  PERIOD_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut,
  output logic              updateFlag
);

  dpCtrl_t           dpCtrl;
  logic [DATA_W-1:0] prePeriod;
  logic [DATA_W-1:0] preCompare;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] actPeriod;
  logic [DATA_W-1:0] actCompare;
  logic              atPeriodEnd;
  logic              updateDisable;

  pwm_reg_ctrl #(
    .DATA_W     (DATA_W),
    .PERIOD_RST (PERIOD_RST)
  ) ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .rdEn          (rdEn),
    .addr          (addr),
    .wrData        (wrData),
    .atPeriodEnd   (atPeriodEnd),
    .dpCtrl        (dpCtrl),
    .prePeriod     (prePeriod),
    .preCompare    (preCompare),
    .rdData        (rdData),
    .updateFlag    (updateFlag),
    .updateDisable (updateDisable)
  );

  pwm_datapath #(
    .DATA_W     (DATA_W),
    .PERIOD_RST (PERIOD_RST)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .dpCtrl      (dpCtrl),
    .prePeriod   (prePeriod),
    .preCompare  (preCompare),
    .cnt         (cnt),
    .actPeriod   (actPeriod),
    .actCompare  (actCompare),
    .atPeriodEnd (atPeriodEnd),
    .pwmOut      (pwmOut)
  );

endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              genBit,
  input logic              pwmOut,
  input logic              updateFlag,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] actPeriod,
  input logic [DATA_W-1:0] actCompare,
  input logic              countEn,
  input logic              updateDisable,
  input outMode_e          outMode
);

  logic genWrite;
  assign genWrite = wrEn && (addr == ADDR_EVENT) && genBit;

  // R1
  cnt_within_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= actPeriod);

  // R6
  pair_loads_with_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actPeriod != $past(actPeriod) || actCompare != $past(actCompare)) |-> updateFlag);

  // R5
  hold_blocks_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateFlag |-> !$past(updateDisable));

  // R4
  forced_update_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (genWrite && !updateDisable) |=> (updateFlag && cnt == '0));

  // R8
  forced_mode_counts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outMode != OUT_PWM && countEn && cnt != actPeriod && !genWrite)
      |=> cnt == $past(cnt) + 1'b1);

  // R8
  forced_high_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == OUT_HIGH) |-> pwmOut);

  // R9
  stopped_counter_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !genWrite) |=> $stable(cnt));

  // R3
  compare_above_period_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == OUT_PWM && actCompare > actPeriod) |-> pwmOut);

  // R2
  zero_compare_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == OUT_PWM && actCompare == '0) |-> !pwmOut);

endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(.DATA_W(DATA_W)) chk (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .addr          (addr),
  .genBit        (wrData[0]),
  .pwmOut        (pwmOut),
  .updateFlag    (updateFlag),
  .cnt           (cnt),
  .actPeriod     (actPeriod),
  .actCompare    (actCompare),
  .countEn       (dpCtrl.countEn),
  .updateDisable (updateDisable),
  .outMode       (dpCtrl.outMode)
);

// File: tb/pwm_shadow_timer_test.sv
module pwm_shadow_timer_test;
  import pwm_shadow_pkg::*;

  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrEn;
  logic              rdEn;
  logic [1:0]        addr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;
  logic              pwmOut;
  logic              updateFlag;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    int          at;
    int          kind;   // 0 pwmOut, 1 updateFlag, 2 rdData
    logic [15:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  pwm_shadow_timer #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut), .updateFlag(updateFlag)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare expected items at their cycle
  always @(negedge clk) begin
    #1;
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at == cyc) begin
        logic [15:0] act;
        case (expQ[i].kind)
          0:       act = {15'b0, pwmOut};
          1:       act = {15'b0, updateFlag};
          default: act = rdData;
        endcase
        checks++;
        if (act !== expQ[i].val) begin
          fails++;
          $display("FAIL %s (cycle %0d): actual %0h expected %0h",
                   expQ[i].tag, cyc, act, expQ[i].val);
        end
        expQ.delete(i);
      end
    end
  end

  // Driver side
  task automatic push(input int kind, input int at, input logic [15:0] val, input string tag);
    expItem_t it;
    it.at = at; it.kind = kind; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [1:0] a, input logic [15:0] exp, input string tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    push(2, cyc, exp, tag);
  endtask

  task automatic expectConst(input int kind, input int from, input int n,
                             input logic val, input string tag);
    for (int c = from; c < from + n; c++) push(kind, c, {15'b0, val}, tag);
  endtask

  task automatic expectPwm(input int syncC, input int per, input int cmp, input int from,
                           input int n, input bit doOut, input bit doFlag, input string tag);
    for (int c = from; c < from + n; c++) begin
      int k;
      k = (c - syncC) % (per + 1);
      if (doOut)  push(0, c, {15'b0, (k < cmp)}, tag);
      if (doFlag) push(1, c, {15'b0, (k == 0)}, tag);
    end
  endtask

  task automatic finishRun();
    if (expQ.size() != 0) begin
      fails += expQ.size();
      checks += expQ.size();
      $display("FAIL leftover expectations: actual %0d pending expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, u, m, k, held;
    wrEn = 0; rdEn = 0; addr = 0; wrData = 0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R11 reset state
    push(0, cyc, 16'h0, "R11 output low after reset");
    push(1, cyc, 16'h0, "R11 flag low after reset");
    readReg(ADDR_CTRL, 16'h0, "R11 control reads zero");
    readReg(ADDR_PERIOD, 16'hFFFF, "R11 period preload all ones");
    readReg(ADDR_COMPARE, 16'h0, "R11 compare preload zero");
    readReg(ADDR_EVENT, 16'h0, "R10 event register reads zero");

    // R6: preload writes alone leave output untouched
    writeReg(ADDR_PERIOD, 16'd4);
    writeReg(ADDR_COMPARE, 16'd2);
    expectConst(0, cyc, 4, 1'b0, "R6 preload without update keeps output low");
    expectConst(1, cyc, 4, 1'b0, "R6 no update flag from preload write");
    repeat (4) @(negedge clk);
    readReg(ADDR_PERIOD, 16'd4, "R10 period preload readback");

    // R1 R2 R4 R7: forced update then free running, period 4 compare 2
    writeReg(ADDR_CTRL, 16'h1);
    writeReg(ADDR_EVENT, 16'h1);
    s = cyc;
    expectPwm(s, 4, 2, s, 20, 1, 1, "R1 R2 R7 period 5 pulse 2");
    repeat (6) @(negedge clk);
    writeReg(ADDR_EVENT, 16'h0);  // R4 zero write has no effect
    repeat (14) @(negedge clk);

    // R3: compare above period
    writeReg(ADDR_PERIOD, 16'd2);
    writeReg(ADDR_COMPARE, 16'd3);
    writeReg(ADDR_EVENT, 16'h1);
    s = cyc;
    expectPwm(s, 2, 3, s, 9, 1, 1, "R3 compare above period stays high");
    repeat (9) @(negedge clk);

    // R3: compare equal to period
    writeReg(ADDR_COMPARE, 16'd2);
    writeReg(ADDR_EVENT, 16'h1);
    s = cyc;
    expectPwm(s, 2, 2, s, 9, 1, 1, "R3 compare equal to period one low clock");
    repeat (9) @(negedge clk);

    // R5: hold-off suppresses updates, forced write ignored
    writeReg(ADDR_CTRL, 16'h3);
    u = cyc;
    expectPwm(s, 2, 2, u + 1, 14, 1, 0, "R5 pattern unchanged while held");
    expectConst(1, u + 1, 14, 1'b0, "R5 no update flag while held");
    writeReg(ADDR_PERIOD, 16'd9);
    writeReg(ADDR_COMPARE, 16'd1);
    writeReg(ADDR_EVENT, 16'h1);
    repeat (11) @(negedge clk);
    readReg(ADDR_PERIOD, 16'd9, "R10 pending period readback");

    // R6: pair loads after hold-off cleared
    writeReg(ADDR_CTRL, 16'h1);
    writeReg(ADDR_EVENT, 16'h1);
    s = cyc;
    expectPwm(s, 9, 1, s, 20, 1, 1, "R6 pair loads together after release");
    repeat (20) @(negedge clk);

    // R8: forced high then forced low, counter keeps running
    writeReg(ADDR_CTRL, 16'h5);
    m = cyc;
    expectConst(0, m, 12, 1'b1, "R8 forced high level");
    expectPwm(s, 9, 1, m, 12, 0, 1, "R8 updates continue while forced high");
    repeat (12) @(negedge clk);
    writeReg(ADDR_CTRL, 16'h9);
    m = cyc;
    expectConst(0, m, 12, 1'b0, "R8 forced low level");
    expectPwm(s, 9, 1, m, 12, 0, 1, "R8 updates continue while forced low");
    repeat (12) @(negedge clk);
    readReg(ADDR_CTRL, 16'h9, "R10 control readback");
    writeReg(ADDR_CTRL, 16'h1);
    m = cyc;
    expectPwm(s, 9, 1, m, 10, 1, 1, "R8 PWM resumes in phase");
    repeat (10) @(negedge clk);

    // R9: stop counting holds output and suppresses wraps
    writeReg(ADDR_CTRL, 16'h0);
    k = cyc;
    held = (k - s) % 10;
    expectConst(0, k + 1, 8, (held < 1), "R9 output holds while stopped");
    expectConst(1, k + 1, 8, 1'b0, "R9 no wrap while stopped");
    repeat (9) @(negedge clk);

    // R12: zero period with large compare gives constant high
    writeReg(ADDR_CTRL, 16'h1);
    writeReg(ADDR_PERIOD, 16'd0);
    writeReg(ADDR_COMPARE, 16'hFFFF);
    writeReg(ADDR_EVENT, 16'h1);
    s = cyc;
    expectConst(0, s, 6, 1'b1, "R12 output high at once");
    expectConst(1, s, 6, 1'b1, "R12 update on every clock");
    repeat (7) @(negedge clk);

    finished = 1;
    finishRun();
  end

endmodule